// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions of a speculative out-of-order core in issue order, from the cycle they issue to the cycle they retire. Each issuing instruction claims the slot at the tail and gets the slot index back as its result tag. Functional units later return results over a shared result bus using that tag. The buffer holds the value and serves it to younger instructions through an operand read port until the owner retires.

Retirement is strictly in order from the head, and only when the head slot holds a result. A register operation drives a register-file write port, a store drives a memory store port, and a branch retires silently. Mispredictions and exceptions are recorded in the slot when the result arrives and take effect only at retirement. Either one discards every slot in one cycle and pulses a flush output for the surrounding pipeline.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: occupancy 0, alloc_ready 1, alloc_tag 0, and no retire, write, store, flush or exception output is active.
- R2: An allocation is taken when alloc_valid and alloc_ready are both 1. alloc_tag shows the slot it takes, and successive allocations take consecutive slots modulo the depth (8). Occupancy counts accepted allocations minus retirements.
- R3: With 8 slots occupied, alloc_ready is 0 and a request is ignored: occupancy and alloc_tag do not change.
- R4: A result-bus write (wb_valid, wb_tag, wb_value) fills the tagged slot. From the next cycle on, the operand port returns rd_ready 1 and that value for the tag. A slot with no result reads rd_ready 0.
- R5: When rd_tag equals the tag being written in the same cycle, the operand port already returns rd_ready 1 and the bus value.
- R6: Only the head slot may retire, and only when it holds a result. Younger slots that hold results wait.
- R7: A retiring register operation (kind code 2) raises rf_we for one cycle with rf_addr equal to the low REG_W bits of its destination and rf_data equal to its value. It raises no store.
- R8: A retiring store (kind code 1) raises st_we with st_addr equal to its destination and st_data equal to its value. It raises no register write.
- R9: A retiring branch (kind code 0) whose result carried wb_misp 0 raises retire_o only, with neither write port active.
- R10: A branch that retires with wb_misp 1 raises flush_o and no write. alloc_ready is 0 in that cycle. On the next cycle occupancy is 0 and alloc_tag is 0.
- R11: A result carrying wb_exc 1 signals nothing while its slot is not at the head. When the slot retires, exc_valid is 1 with exc_tag equal to its slot, no write port is active, and flush_o empties the buffer.
- R12: A result written to the head slot lets it retire in the same cycle, using the value written.
- R13: With the buffer empty, no retire, write, store, flush or exception output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | Kind: 0 branch, 1 store, 2 register operation |
| alloc_dest | input | DEST_W | Register number or memory address |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Slot index handed to the issuing instruction |
| occupancy | output | CNT_W | Number of occupied slots |
| wb_valid | input | 1 | Result bus carries a result |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_value | input | DATA_W | Result value (store data for stores) |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_misp | input | 1 | Branch was mispredicted |
| rd_tag | input | TAG_W | Operand lookup slot |
| rd_ready | output | 1 | Looked-up slot holds a result |
| rd_value | output | DATA_W | Looked-up result value |
| retire_o | output | 1 | Head slot retires normally this cycle |
| flush_o | output | 1 | All slots discarded this cycle |
| exc_valid | output | 1 | Precise exception from the head slot |
| exc_tag | output | TAG_W | Slot raising the exception |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | REG_W | Register-file write address |
| rf_data | output | DATA_W | Register-file write data |
| st_we | output | 1 | Memory store enable |
| st_addr | output | DEST_W | Store address |
| st_data | output | DATA_W | Store data |

## Verification
On every cycle the assertions check the bookkeeping invariants: occupancy never exceeds the depth and tracks accepted allocations minus retirements, tags advance by one per allocation, a full or flushing buffer refuses slots, an empty buffer is silent, at most one of the write, store and flush paths fires, and every exception comes with a flush. Which value reaches which port, and when, only the bench scenarios show. These include in-order retirement behind results that arrive out of order, operand forwarding from stored and in-flight results, the same-cycle write-then-retire at the head, and pointer wrap across several fill levels. The delayed exception and the misprediction flush are also exercised only there.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
   typedef enum logic [1:0] {
      ROB_BR = 2'd0,
      ROB_ST = 2'd1,
      ROB_RG = 2'd2
   } rob_kind_e;

   typedef struct packed {
      logic ready;
      logic exc;
      logic misp;
   } rob_flags_t;
endpackage

// File: rtl/rob_ptr_ctrl.sv
`timescale 1ns/1ps
module rob_ptr_ctrl #(
   parameter int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_fire,
   input  logic             retire_fire,
   input  logic             flush,
   output logic [TAG_W-1:0] head,
   output logic [TAG_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
      $error("rob_ptr_ctrl: DEPTH must be a power of two, at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (alloc_fire)  tail <= tail + 1'b1;
         if (retire_fire) head <= head + 1'b1;
         count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
      end
   end

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
endmodule

// File: rtl/rob_entry_array.sv
`timescale 1ns/1ps
module rob_entry_array
   import rob_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int DEST_W     = 16,
   parameter int DATA_W     = 32,
   parameter bit FWD_BYPASS = 1'b1,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_fire,
   input  logic [TAG_W-1:0]  alloc_idx,
   input  rob_kind_e         alloc_kind,
   input  logic [DEST_W-1:0] alloc_dest,
   input  logic              wb_valid,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_value,
   input  logic              wb_exc,
   input  logic              wb_misp,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_ready,
   output logic [DATA_W-1:0] rd_value,
   input  logic [TAG_W-1:0]  head_idx,
   output rob_kind_e         head_kind,
   output logic [DEST_W-1:0] head_dest,
   output logic [DATA_W-1:0] head_value,
   output rob_flags_t        head_flags
);
   rob_flags_t        flg_a  [DEPTH];
   rob_kind_e         kind_a [DEPTH];
   logic [DEST_W-1:0] dest_a [DEPTH];
   logic [DATA_W-1:0] val_a  [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      rob_flags_t        flg_q;
      rob_kind_e         kind_q;
      logic [DEST_W-1:0] dest_q;
      logic [DATA_W-1:0] val_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flg_q  <= '0;
            kind_q <= ROB_BR;
            dest_q <= '0;
            val_q  <= '0;
         end else begin
            if (alloc_fire && alloc_idx == TAG_W'(e)) begin
               flg_q  <= '0;
               kind_q <= alloc_kind;
               dest_q <= alloc_dest;
            end
            if (wb_valid && wb_tag == TAG_W'(e)) begin
               flg_q <= '{ready: 1'b1, exc: wb_exc, misp: wb_misp};
               val_q <= wb_value;
            end
         end
      end

      assign flg_a[e]  = flg_q;
      assign kind_a[e] = kind_q;
      assign dest_a[e] = dest_q;
      assign val_a[e]  = val_q;
   end

   // Head view: a same-cycle result for the head slot wins over stored state.
   logic wb_hits_head;
   assign wb_hits_head = wb_valid && (wb_tag == head_idx);
   assign head_kind    = kind_a[head_idx];
   assign head_dest    = dest_a[head_idx];
   assign head_value   = wb_hits_head ? wb_value : val_a[head_idx];
   assign head_flags   = wb_hits_head ? '{ready: 1'b1, exc: wb_exc, misp: wb_misp}
                                      : flg_a[head_idx];

   // Operand port: variant chosen by FWD_BYPASS.
   if (FWD_BYPASS) begin : g_rd_bypass
      logic wb_hits_rd;
      assign wb_hits_rd = wb_valid && (wb_tag == rd_tag);
      assign rd_ready   = wb_hits_rd || flg_a[rd_tag].ready;
      assign rd_value   = wb_hits_rd ? wb_value : val_a[rd_tag];
   end else begin : g_rd_stored
      assign rd_ready = flg_a[rd_tag].ready;
      assign rd_value = val_a[rd_tag];
   end
endmodule

// File: rtl/rob_commit_unit.sv
`timescale 1ns/1ps
module rob_commit_unit
   import rob_pkg::*;
#(
   parameter int TAG_W  = 3,
   parameter int DEST_W = 16,
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input  logic              nonempty,
   input  logic [TAG_W-1:0]  head_idx,
   input  rob_kind_e         head_kind,
   input  logic [DEST_W-1:0] head_dest,
   input  logic [DATA_W-1:0] head_value,
   input  rob_flags_t        head_flags,
   output logic              retire,
   output logic              flush,
   output logic              exc_valid,
   output logic [TAG_W-1:0]  exc_tag,
   output logic              rf_we,
   output logic [REG_W-1:0]  rf_addr,
   output logic [DATA_W-1:0] rf_data,
   output logic              st_we,
   output logic [DEST_W-1:0] st_addr,
   output logic [DATA_W-1:0] st_data
);
   if (REG_W > DEST_W) begin : g_regw_chk
      $error("rob_commit_unit: REG_W must not exceed DEST_W");
   end

   logic go, misp_br;
   always_comb begin
      go        = nonempty && head_flags.ready;
      misp_br   = (head_kind == ROB_BR) && head_flags.misp;
      exc_valid = go && head_flags.exc;
      flush     = go && (head_flags.exc || misp_br);
      retire    = go && !flush;
      rf_we     = retire && (head_kind == ROB_RG);
      st_we     = retire && (head_kind == ROB_ST);
   end

   assign exc_tag = head_idx;
   assign rf_addr = head_dest[REG_W-1:0];
   assign rf_data = head_value;
   assign st_addr = head_dest;
   assign st_data = head_value;
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core
   import rob_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int DATA_W     = 32,
   parameter int DEST_W     = 16,
   parameter int REG_W      = 5,
   parameter bit FWD_BYPASS = 1'b1,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [1:0]        alloc_kind,
   input  logic [DEST_W-1:0] alloc_dest,
   output logic              alloc_ready,
   output logic [TAG_W-1:0]  alloc_tag,
   output logic [CNT_W-1:0]  occupancy,
   input  logic              wb_valid,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_value,
   input  logic              wb_exc,
   input  logic              wb_misp,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_ready,
   output logic [DATA_W-1:0] rd_value,
   output logic              retire_o,
   output logic              flush_o,
   output logic              exc_valid,
   output logic [TAG_W-1:0]  exc_tag,
   output logic              rf_we,
   output logic [REG_W-1:0]  rf_addr,
   output logic [DATA_W-1:0] rf_data,
   output logic              st_we,
   output logic [DEST_W-1:0] st_addr,
   output logic [DATA_W-1:0] st_data
);
   if (DATA_W < 1 || DEST_W < 1 || REG_W < 1) begin : g_width_chk
      $error("rob_core: widths must be positive");
   end

   logic             full, empty, alloc_fire;
   logic [TAG_W-1:0] head, tail;
   rob_kind_e        head_kind;
   logic [DEST_W-1:0] head_dest;
   logic [DATA_W-1:0] head_value;
   rob_flags_t       head_flags;

   assign alloc_ready = !full && !flush_o;
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign alloc_tag   = tail;

   rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_fire  (alloc_fire),
      .retire_fire (retire_o),
      .flush       (flush_o),
      .head        (head),
      .tail        (tail),
      .count       (occupancy),
      .full        (full),
      .empty       (empty)
   );

   rob_entry_array #(
      .DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .FWD_BYPASS(FWD_BYPASS)
   ) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .alloc_idx  (tail),
      .alloc_kind (rob_kind_e'(alloc_kind)),
      .alloc_dest (alloc_dest),
      .wb_valid   (wb_valid),
      .wb_tag     (wb_tag),
      .wb_value   (wb_value),
      .wb_exc     (wb_exc),
      .wb_misp    (wb_misp),
      .rd_tag     (rd_tag),
      .rd_ready   (rd_ready),
      .rd_value   (rd_value),
      .head_idx   (head),
      .head_kind  (head_kind),
      .head_dest  (head_dest),
      .head_value (head_value),
      .head_flags (head_flags)
   );

   rob_commit_unit #(
      .TAG_W(TAG_W), .DEST_W(DEST_W), .DATA_W(DATA_W), .REG_W(REG_W)
   ) u_commit (
      .nonempty   (!empty),
      .head_idx   (head),
      .head_kind  (head_kind),
      .head_dest  (head_dest),
      .head_value (head_value),
      .head_flags (head_flags),
      .retire     (retire_o),
      .flush      (flush_o),
      .exc_valid  (exc_valid),
      .exc_tag    (exc_tag),
      .rf_we      (rf_we),
      .rf_addr    (rf_addr),
      .rf_data    (rf_data),
      .st_we      (st_we),
      .st_addr    (st_addr),
      .st_data    (st_data)
   );
endmodule

// File: rtl/rob_core_chk.sv
`timescale 1ns/1ps
module rob_core_chk #(
   parameter int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             alloc_ready,
   input logic [TAG_W-1:0] alloc_tag,
   input logic [CNT_W-1:0] occupancy,
   input logic             retire_o,
   input logic             flush_o,
   input logic             exc_valid,
   input logic             rf_we,
   input logic             st_we
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= CNT_W'(DEPTH)); // R3
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == CNT_W'(DEPTH)) |-> !alloc_ready); // R3
   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == '0) |-> !(retire_o || rf_we || st_we || flush_o || exc_valid)); // R13
   AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && alloc_ready) |=> alloc_tag == TAG_W'($past(alloc_tag) + 1'b1)); // R2
   AST_OCC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_o |=> occupancy == $past(occupancy + CNT_W'(alloc_valid && alloc_ready)
                                      - CNT_W'(retire_o))); // R2
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> (occupancy == '0 && alloc_tag == '0)); // R10
   AST_FLUSH_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !alloc_ready); // R10
   AST_EXC_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (flush_o && !rf_we && !st_we)); // R11
   AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_we, st_we, flush_o})); // R7
   AST_WRITE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we || st_we) |-> retire_o); // R6
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_valid (alloc_valid),
   .alloc_ready (alloc_ready),
   .alloc_tag   (alloc_tag),
   .occupancy   (occupancy),
   .retire_o    (retire_o),
   .flush_o     (flush_o),
   .exc_valid   (exc_valid),
   .rf_we       (rf_we),
   .st_we       (st_we)
);

// File: tb/rob_core_tb_top.sv
`timescale 1ns/1ps
module rob_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        alloc_valid;
   logic [1:0]  alloc_kind;
   logic [15:0] alloc_dest;
   logic        alloc_ready;
   logic [2:0]  alloc_tag;
   logic [3:0]  occupancy;
   logic        wb_valid;
   logic [2:0]  wb_tag;
   logic [31:0] wb_value;
   logic        wb_exc, wb_misp;
   logic [2:0]  rd_tag;
   logic        rd_ready;
   logic [31:0] rd_value;
   logic        retire_o, flush_o, exc_valid;
   logic [2:0]  exc_tag;
   logic        rf_we;
   logic [4:0]  rf_addr;
   logic [31:0] rf_data;
   logic        st_we;
   logic [15:0] st_addr;
   logic [31:0] st_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int tail_m = 0;

   int kkind [8];
   int kdest [8];
   int kval  [8];
   int ktag  [8];

   always #5 clk = ~clk;

   rob_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
      .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .occupancy(occupancy),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
      .wb_exc(wb_exc), .wb_misp(wb_misp),
      .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_value(rd_value),
      .retire_o(retire_o), .flush_o(flush_o), .exc_valid(exc_valid), .exc_tag(exc_tag),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
      .st_we(st_we), .st_addr(st_addr), .st_data(st_data)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 0; alloc_kind = 0; alloc_dest = 0;
      wb_valid = 0; wb_tag = 0; wb_value = 0; wb_exc = 0; wb_misp = 0;
      rd_tag = 0;
   endtask

   task automatic do_alloc(input int i, input int kind, input int dest, input string req);
      @(negedge clk); idle();
      alloc_valid = 1; alloc_kind = 2'(kind); alloc_dest = 16'(dest);
      #1;
      chk(req, "alloc_ready", alloc_ready, 1);
      chk(req, "alloc_tag", alloc_tag, tail_m % 8);
      kkind[i] = kind; kdest[i] = dest; ktag[i] = tail_m % 8;
      tail_m++;
   endtask

   task automatic chk_commit(input int i, input string hreq);
      string req;
      req = (hreq != "") ? hreq : (kkind[i] == 2) ? "R7" : (kkind[i] == 1) ? "R8" : "R9";
      chk(req, "retire_o", retire_o, 1);
      chk(req, "flush_o", flush_o, 0);
      chk(req, "rf_we", rf_we, (kkind[i] == 2) ? 1 : 0);
      chk(req, "st_we", st_we, (kkind[i] == 1) ? 1 : 0);
      if (kkind[i] == 2) begin
         chk(req, "rf_addr", rf_addr, kdest[i] % 32);
         chk(req, "rf_data", rf_data, kval[i]);
      end
      if (kkind[i] == 1) begin
         chk(req, "st_addr", st_addr, kdest[i]);
         chk(req, "st_data", st_data, kval[i]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; idle();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1; #1;
      // R1 reset state
      chk("R1", "occupancy", occupancy, 0);
      chk("R1", "alloc_ready", alloc_ready, 1);
      chk("R1", "alloc_tag", alloc_tag, 0);
      chk("R1", "retire_o", retire_o, 0);
      chk("R1", "rf_we", rf_we, 0);
      chk("R1", "st_we", st_we, 0);
      chk("R1", "flush_o", flush_o, 0);
      chk("R1", "exc_valid", exc_valid, 0);

      // Sweep over fill levels 1..8 with mixed kinds; pointers wrap along the way.
      for (int r = 0; r < 8; r++) begin
         int n;
         n = r + 1;
         for (int i = 0; i < n; i++) begin
            do_alloc(i, (i + r) % 3, r * 16 + i, "R2");
            kval[i] = r * 1000 + i * 7 + 1;
         end
         @(negedge clk); idle(); #1;
         chk("R2", "occupancy", occupancy, n);
         // results arrive youngest first; R5 forwarding of the in-flight value
         for (int i = n - 1; i >= 1; i--) begin
            @(negedge clk); idle();
            wb_valid = 1; wb_tag = 3'(ktag[i]); wb_value = 32'(kval[i]); rd_tag = 3'(ktag[i]);
            #1;
            chk("R5", "rd_ready", rd_ready, 1);
            chk("R5", "rd_value", rd_value, kval[i]);
            chk("R6", "retire_o", retire_o, 0);
         end
         // R4 stored results readable; head still pending
         for (int i = 1; i < n; i++) begin
            @(negedge clk); idle(); rd_tag = 3'(ktag[i]); #1;
            chk("R4", "rd_ready", rd_ready, 1);
            chk("R4", "rd_value", rd_value, kval[i]);
            chk("R6", "retire_o", retire_o, 0);
         end
         @(negedge clk); idle(); rd_tag = 3'(ktag[0]); #1;
         chk("R4", "rd_ready head pending", rd_ready, 0);
         chk("R6", "retire_o", retire_o, 0);
         // R12 head result and retire in one cycle
         @(negedge clk); idle();
         wb_valid = 1; wb_tag = 3'(ktag[0]); wb_value = 32'(kval[0]);
         #1;
         chk_commit(0, "R12");
         for (int i = 1; i < n; i++) begin
            @(negedge clk); idle(); #1;
            chk_commit(i, "");
         end
         @(negedge clk); idle(); #1;
         chk("R13", "occupancy", occupancy, 0);
         chk("R13", "retire_o", retire_o, 0);
         chk("R13", "rf_we", rf_we, 0);
         chk("R13", "st_we", st_we, 0);
      end

      // R3 full buffer, then R10 misprediction flush from a branch at the head
      for (int i = 0; i < 8; i++) do_alloc(i, (i == 0) ? 0 : 2, 100 + i, "R2");
      @(negedge clk); idle(); #1;
      chk("R3", "occupancy", occupancy, 8);
      chk("R3", "alloc_ready", alloc_ready, 0);
      alloc_valid = 1; alloc_kind = 2;
      @(negedge clk); idle(); #1;
      chk("R3", "occupancy after refused", occupancy, 8);
      chk("R3", "alloc_tag after refused", alloc_tag, tail_m % 8);
      for (int i = 1; i < 8; i++) begin
         @(negedge clk); idle();
         wb_valid = 1; wb_tag = 3'(ktag[i]); wb_value = 32'(500 + i);
      end
      @(negedge clk); idle();
      wb_valid = 1; wb_tag = 3'(ktag[0]); wb_misp = 1; alloc_valid = 1; alloc_kind = 2;
      #1;
      chk("R10", "flush_o", flush_o, 1);
      chk("R10", "rf_we", rf_we, 0);
      chk("R10", "retire_o", retire_o, 0);
      chk("R10", "alloc_ready", alloc_ready, 0);
      @(negedge clk); idle(); #1;
      chk("R10", "occupancy", occupancy, 0);
      chk("R10", "alloc_tag", alloc_tag, 0);
      chk("R10", "flush_o after", flush_o, 0);
      tail_m = 0;

      // R11 exception recorded on a store, signalled only at the head
      do_alloc(0, 2, 40, "R2");
      do_alloc(1, 1, 41, "R2");
      do_alloc(2, 2, 42, "R2");
      @(negedge clk); idle();
      wb_valid = 1; wb_tag = 3'd1; wb_value = 55; wb_exc = 1;
      #1;
      chk("R11", "exc_valid early", exc_valid, 0);
      chk("R11", "flush_o early", flush_o, 0);
      @(negedge clk); idle();
      wb_valid = 1; wb_tag = 3'd0; wb_value = 77;
      kval[0] = 77;
      #1;
      chk_commit(0, "R7");
      chk("R11", "exc_valid older retire", exc_valid, 0);
      @(negedge clk); idle(); #1;
      chk("R11", "exc_valid", exc_valid, 1);
      chk("R11", "exc_tag", exc_tag, 1);
      chk("R11", "st_we", st_we, 0);
      chk("R11", "flush_o", flush_o, 1);
      @(negedge clk); idle(); #1;
      chk("R11", "occupancy", occupancy, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule